// File: doc/BRIEF.md
# ADC reference calibration loop

This block keeps the two 3-bit baseband converters (I and Q) near their best operating point by servoing how often they clip. On every valid sample it checks whether either converter sits at a full-scale code. It then moves a 24-bit accumulator up by one programmed signed step when either converter clips, or by a second programmed signed step when neither does. The accumulator settles where P·up + (1−P)·down = 0. With steps of +1 and −1 the converters clip half of the time.

Only the five most significant accumulator bits reach the reference-adjust DAC code, which keeps the loop gain low. That code is refreshed only on a slow periodic tick, nominally 1 kHz, so the loop follows slow gain drift and does not act as an AGC. The loop is controlled by a small state machine with three states: CAL_OFF, CAL_WAIT and CAL_RUN.

The next state is decided from the mode and the gate inputs:
- Mode 00 or 01 enters CAL_OFF. In CAL_OFF the code is pinned to mid-scale and the accumulator is preset to mid-scale.
- Mode 10 goes to CAL_RUN while `rx_track` is high and to CAL_WAIT otherwise.
- Mode 11 goes to CAL_RUN while `rx_en` is high and to CAL_WAIT otherwise.
- In CAL_WAIT the accumulator holds its value and the tick keeps counting.

Top module: `adc_ref_cal`

## Requirements
- R1: Full scale is the 3-bit two's-complement code 3'b011 or 3'b100 on I or on Q. A sample strobe that finds either channel at full scale adds `step_up`. A strobe that finds neither at full scale adds `step_dn`.
- R2: In a cycle with `samp_vld` low, the accumulator does not change.
- R3: `dac_code` changes only on the periodic tick, which fires once every TICK_DIV clocks counted from the exit from CAL_OFF. On the tick, `dac_code` loads accumulator bits [23:19].
- R4: With `cal_mode` at 2'b00 or 2'b01, the state is CAL_OFF. From the second clock on, `dac_code` is 5'b10000 and the accumulator is 24'h800000.
- R5: Mode 2'b10 accumulates only while `rx_track` is high, and mode 2'b11 only while `rx_en` is high. The mode and gate inputs take effect one clock after they are sampled.
- R6: `step_up` and `step_dn` are 16-bit two's-complement values. A negative step lowers the accumulator.
- R7: The accumulator clamps at 24'h000000 and 24'hFFFFFF and never wraps.
- R8: `cal_mon` is {`dac_code`, accumulator bits [23:8]}.
- R9: After reset, `dac_code` is 5'b10000, the accumulator is 24'h800000 and the state is CAL_OFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample-rate clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| samp_i | input | 3 | I converter sample, two's complement |
| samp_q | input | 3 | Q converter sample, two's complement |
| samp_vld | input | 1 | Sample strobe |
| rx_track | input | 1 | Receiver is tracking |
| rx_en | input | 1 | Receiver enabled |
| cal_mode | input | 2 | 0x: off at mid-scale, 10: run while tracking, 11: run while enabled |
| step_up | input | 16 | Signed step applied on a full-scale sample |
| step_dn | input | 16 | Signed step applied otherwise |
| dac_code | output | 5 | Reference-adjust DAC code |
| cal_mon | output | 21 | Monitor: code and upper accumulator bits |

## Verification
The accumulator field of `cal_mon` reflects a strobe one clock after that strobe, and the mode and gate inputs take one further clock to reach the state register. The bench therefore holds configuration for two clocks before any strobe, and it reads the monitor on the falling edge after the last strobe. `dac_code` is due only after a tick, so each code check waits more than TICK_DIV clocks with no strobes. One directed case reads the code inside the first tick window to show that it has not yet moved. The off-mode preset takes two clocks, and checks of it wait that long.

// File: rtl/adc_cal_pkg.sv
package adc_cal_pkg;
    typedef enum logic [1:0] {
        CAL_OFF  = 2'd0,
        CAL_WAIT = 2'd1,
        CAL_RUN  = 2'd2
    } cal_state_t;

    localparam logic [1:0] MODE_TRACK = 2'b10;
    localparam logic [1:0] MODE_RXEN  = 2'b11;
endpackage

// File: rtl/adc_sat_detect.sv
module adc_sat_detect #(
    parameter int SAMP_W = 3
) (
    input  logic [SAMP_W-1:0] samp_i,
    input  logic [SAMP_W-1:0] samp_q,
    output logic              any_full
);
    localparam logic [SAMP_W-1:0] POS_FS = {1'b0, {(SAMP_W-1){1'b1}}};
    localparam logic [SAMP_W-1:0] NEG_FS = {1'b1, {(SAMP_W-1){1'b0}}};

    logic [1:0] ch_full;
    logic [SAMP_W-1:0] ch_samp [2];

    assign ch_samp[0] = samp_i;
    assign ch_samp[1] = samp_q;

    for (genvar c = 0; c < 2; c++) begin : g_ch
        assign ch_full[c] = (ch_samp[c] == POS_FS) || (ch_samp[c] == NEG_FS);
    end

    assign any_full = |ch_full;
endmodule

// File: rtl/adc_cal_fsm.sv
module adc_cal_fsm
    import adc_cal_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] cal_mode,
    input  logic       rx_track,
    input  logic       rx_en,
    input  logic       samp_vld,
    output cal_state_t state,
    output logic       acc_en,
    output logic       preset
);
    cal_state_t state_q, state_d;
    logic gate;

    always_comb begin
        gate = 1'b0;
        unique case (cal_mode)
            MODE_TRACK: gate = rx_track;
            MODE_RXEN:  gate = rx_en;
            default:    gate = 1'b0;
        endcase
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CAL_OFF: begin
                if (cal_mode[1]) state_d = gate ? CAL_RUN : CAL_WAIT;
            end
            CAL_WAIT: begin
                if (!cal_mode[1]) state_d = CAL_OFF;
                else if (gate)    state_d = CAL_RUN;
            end
            CAL_RUN: begin
                if (!cal_mode[1]) state_d = CAL_OFF;
                else if (!gate)   state_d = CAL_WAIT;
            end
            default: state_d = CAL_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CAL_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        acc_en = 1'b0;
        preset = 1'b0;
        unique case (state_q)
            CAL_OFF:  preset = 1'b1;
            CAL_WAIT: acc_en = 1'b0;
            CAL_RUN:  acc_en = samp_vld;
            default:  preset = 1'b1;
        endcase
    end

    assign state = state_q;
endmodule

// File: rtl/adc_cal_tick.sv
module adc_cal_tick #(
    parameter int TICK_DIV = 22000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    output logic tick
);
    localparam int CNT_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_DIV - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cnt_q <= '0;
        else if (clear)        cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                   cnt_q <= cnt_q + 1'b1;
    end

    assign tick = !clear && (cnt_q == LAST);
endmodule

// File: rtl/adc_cal_accum.sv
module adc_cal_accum #(
    parameter int ACC_W  = 24,
    parameter int STEP_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              preset,
    input  logic              en,
    input  logic              full,
    input  logic [STEP_W-1:0] step_up,
    input  logic [STEP_W-1:0] step_dn,
    output logic [ACC_W-1:0]  acc
);
    localparam int SUM_W = ACC_W + 2;
    localparam logic [ACC_W-1:0] MID = {1'b1, {(ACC_W-1){1'b0}}};
    localparam logic signed [SUM_W-1:0] MAXV = {2'b00, {ACC_W{1'b1}}};

    logic [ACC_W-1:0] acc_q;
    logic [STEP_W-1:0] step;
    logic signed [SUM_W-1:0] step_x, sum;
    logic [ACC_W-1:0] next_acc;

    always_comb begin
        step   = full ? step_up : step_dn;
        step_x = {{(SUM_W-STEP_W){step[STEP_W-1]}}, step};
        sum    = $signed({2'b00, acc_q}) + step_x;
        if (sum < 0)         next_acc = '0;
        else if (sum > MAXV) next_acc = {ACC_W{1'b1}};
        else                 next_acc = sum[ACC_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      acc_q <= MID;
        else if (preset) acc_q <= MID;
        else if (en)     acc_q <= next_acc;
    end

    assign acc = acc_q;
endmodule

// File: rtl/adc_ref_cal.sv
module adc_ref_cal
    import adc_cal_pkg::*;
#(
    parameter int SAMP_W    = 3,
    parameter int ACC_W     = 24,
    parameter int CODE_W    = 5,
    parameter int STEP_W    = 16,
    parameter int MON_ACC_W = 16,
    parameter int TICK_DIV  = 22000
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [SAMP_W-1:0]           samp_i,
    input  logic [SAMP_W-1:0]           samp_q,
    input  logic                        samp_vld,
    input  logic                        rx_track,
    input  logic                        rx_en,
    input  logic [1:0]                  cal_mode,
    input  logic [STEP_W-1:0]           step_up,
    input  logic [STEP_W-1:0]           step_dn,
    output logic [CODE_W-1:0]           dac_code,
    output logic [CODE_W+MON_ACC_W-1:0] cal_mon
);
    localparam logic [CODE_W-1:0] CODE_MID = {1'b1, {(CODE_W-1){1'b0}}};

    cal_state_t state;
    logic acc_en, preset, full, tick, st_off;
    logic [ACC_W-1:0] acc_q;
    logic [CODE_W-1:0] code_q;

    adc_sat_detect #(.SAMP_W(SAMP_W)) u_sat (
        .samp_i(samp_i), .samp_q(samp_q), .any_full(full)
    );

    adc_cal_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .cal_mode(cal_mode), .rx_track(rx_track),
        .rx_en(rx_en), .samp_vld(samp_vld), .state(state),
        .acc_en(acc_en), .preset(preset)
    );

    assign st_off = (state == CAL_OFF);

    adc_cal_tick #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .clear(st_off), .tick(tick)
    );

    adc_cal_accum #(.ACC_W(ACC_W), .STEP_W(STEP_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .preset(preset), .en(acc_en), .full(full),
        .step_up(step_up), .step_dn(step_dn), .acc(acc_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      code_q <= CODE_MID;
        else if (st_off) code_q <= CODE_MID;
        else if (tick)   code_q <= acc_q[ACC_W-1 -: CODE_W];
    end

    assign dac_code = code_q;
    assign cal_mon  = {code_q, acc_q[ACC_W-1 -: MON_ACC_W]};
endmodule

// File: rtl/adc_ref_cal_chk.sv
module adc_ref_cal_chk #(
    parameter int ACC_W  = 24,
    parameter int CODE_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        cal_mode,
    input logic              rx_track,
    input logic              rx_en,
    input logic [CODE_W-1:0] dac_code,
    input logic [ACC_W-1:0]  acc,
    input logic              tick,
    input logic              st_off,
    input logic              acc_en,
    input logic              full,
    input logic              up_neg
);
    localparam logic [CODE_W-1:0] CODE_MID = {1'b1, {(CODE_W-1){1'b0}}};

    AST_OFF_MID: assert property (@(posedge clk) disable iff (!rst_n)
        (!cal_mode[1] && !$past(cal_mode[1]) && !$past(cal_mode[1], 2)) |-> dac_code == CODE_MID); // R4

    AST_CODE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_code != $past(dac_code)) |-> ($past(tick) || $past(st_off))); // R3

    AST_TRACK_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_mode == 2'b10 && !rx_track) |-> ##2 $stable(acc)); // R5

    AST_RXEN_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_mode == 2'b11 && !rx_en) |-> ##2 $stable(acc)); // R5

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(acc_en) && $past(full) && !$past(up_neg)) |-> acc >= $past(acc)); // R7
endmodule

bind adc_ref_cal adc_ref_cal_chk #(.ACC_W(ACC_W), .CODE_W(CODE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cal_mode(cal_mode), .rx_track(rx_track),
    .rx_en(rx_en), .dac_code(dac_code), .acc(acc_q), .tick(tick),
    .st_off(st_off), .acc_en(acc_en), .full(full), .up_neg(step_up[STEP_W-1])
);

// File: tb/sim_adc_ref_cal.sv
module sim_adc_ref_cal;
    localparam int TDIV = 64;
    localparam logic [23:0] MID = 24'h800000;

    typedef struct packed {
        logic [1:0]  mode;
        logic        trk;
        logic        rxe;
        logic [2:0]  si;
        logic [2:0]  sq;
        logic [15:0] up;
        logic [15:0] dn;
        logic [9:0]  n;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{2'b00, 1'b0, 1'b0, 3'b000, 3'b000, 16'h0100, 16'hFF00, 10'd0},   // R4 preset
        '{2'b11, 1'b0, 1'b1, 3'b011, 3'b000, 16'h0100, 16'hFF00, 10'd5},   // R1 I +fs
        '{2'b11, 1'b0, 1'b1, 3'b010, 3'b101, 16'h0100, 16'hFF00, 10'd3},   // R1 near fs
        '{2'b11, 1'b0, 1'b1, 3'b000, 3'b100, 16'h1000, 16'hFF00, 10'd4},   // R1 Q -fs
        '{2'b11, 1'b1, 1'b0, 3'b011, 3'b011, 16'h1000, 16'hFF00, 10'd6},   // R5 rx_en low
        '{2'b10, 1'b1, 1'b0, 3'b011, 3'b000, 16'h2000, 16'hFF00, 10'd8},   // R5 tracking
        '{2'b10, 1'b0, 1'b1, 3'b011, 3'b000, 16'h2000, 16'hFF00, 10'd8},   // R5 not tracking
        '{2'b11, 1'b0, 1'b1, 3'b100, 3'b001, 16'hF800, 16'h0100, 10'd4},   // R6 negative up
        '{2'b11, 1'b0, 1'b1, 3'b001, 3'b110, 16'h0100, 16'h0400, 10'd2},   // R6 positive down
        '{2'b01, 1'b0, 1'b1, 3'b011, 3'b000, 16'h0100, 16'hFF00, 10'd4},   // R4 mode 01
        '{2'b11, 1'b0, 1'b1, 3'b011, 3'b011, 16'h7FFF, 16'h8000, 10'd300}, // R7 top clamp
        '{2'b11, 1'b0, 1'b1, 3'b000, 3'b000, 16'h7FFF, 16'h8000, 10'd600}  // R7 bottom clamp
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0] samp_i = '0, samp_q = '0;
    logic samp_vld = 1'b0, rx_track = 1'b0, rx_en = 1'b0;
    logic [1:0] cal_mode = 2'b00;
    logic [15:0] step_up = '0, step_dn = '0;
    logic [4:0] dac_code;
    logic [20:0] cal_mon;

    int checks = 0;
    int errors = 0;
    logic [23:0] model = MID;
    logic done = 1'b0;

    always #5 clk = ~clk;

    adc_ref_cal #(.TICK_DIV(TDIV)) u0 (
        .clk(clk), .rst_n(rst_n), .samp_i(samp_i), .samp_q(samp_q),
        .samp_vld(samp_vld), .rx_track(rx_track), .rx_en(rx_en),
        .cal_mode(cal_mode), .step_up(step_up), .step_dn(step_dn),
        .dac_code(dac_code), .cal_mon(cal_mon)
    );

    function automatic logic is_fs(input logic [2:0] s);
        return (s == 3'b011) || (s == 3'b100);
    endfunction

    function automatic logic [23:0] sat_add(input logic [23:0] a, input logic [15:0] st);
        longint v;
        v = longint'(a) + longint'($signed(st));
        if (v < 0) return 24'h0;
        if (v > 64'sd16777215) return 24'hFFFFFF;
        return v[23:0];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        @(negedge clk);
        cal_mode = v.mode; rx_track = v.trk; rx_en = v.rxe;
        samp_i = v.si; samp_q = v.sq; step_up = v.up; step_dn = v.dn;
        repeat (2) @(posedge clk);
        if (!v.mode[1]) model = MID;
    endtask

    task automatic strobe(input vec_t v);
        logic gate;
        gate = (v.mode == 2'b11) ? v.rxe : (v.mode == 2'b10) ? v.trk : 1'b0;
        for (int k = 0; k < int'(v.n); k++) begin
            @(negedge clk); samp_vld = 1'b1;
            @(negedge clk); samp_vld = 1'b0;
            if (gate) model = sat_add(model, (is_fs(v.si) || is_fs(v.sq)) ? v.up : v.dn);
        end
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        done = 1'b1;
    end

    initial begin
        vec_t d;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R9 reset code/acc", 32'(cal_mon), {11'h0, 5'b10000, 16'h8000});
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i]);
            strobe(VEC[i]);
            @(negedge clk);
            check($sformatf("R1/R5/R6/R7/R8 acc vec%0d", i), 32'(cal_mon[15:0]), 32'(model[23:8]));
            repeat (TDIV + 2) @(negedge clk);
            check($sformatf("R3/R4 code vec%0d", i), 32'(dac_code),
                  32'(VEC[i].mode[1] ? model[23:19] : 5'b10000));
            check($sformatf("R2 hold vec%0d", i), 32'(cal_mon[15:0]), 32'(model[23:8]));
        end

        // R3: code must not move inside the first tick window
        d = '{2'b00, 1'b0, 1'b1, 3'b011, 3'b000, 16'h7FFF, 16'h8000, 10'd0};
        apply(d);
        d.mode = 2'b11; d.n = 10'd20;
        apply(d);
        strobe(d);
        @(negedge clk);
        check("R3 code held before tick", 32'(dac_code), 32'h10);
        check("R8 monitor acc", 32'(cal_mon[15:0]), 32'(model[23:8]));
        repeat (TDIV + 2) @(negedge clk);
        check("R3 code after tick", 32'(cal_mon[20:16]), 32'(model[23:19]));

        // R9: mid-run reset restores mid-scale
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check("R9 reset again", 32'(cal_mon), {11'h0, 5'b10000, 16'h8000});
        done = 1'b1;
    end

    initial begin
        wait (done);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule